// File: doc/BRIEF.md
# Secured Configuration Store

This block is the controller for the configuration memory of a small programmable logic device. It keeps three things: an array of fuse-pattern words, a user signature of eight bytes, and one security fuse. A single command port accepts operations that program or verify a fuse word, write or read a signature byte, set the security fuse, request a register preload, or bulk-erase everything. Each completed command gives a one-cycle response carrying read data and an error flag.

The security fuse exists to stop the fuse pattern from being copied. Once it is set, any later fuse verify and any later preload request are refused. The signature bytes stay fully usable in both directions. The security fuse cannot be cleared by any other command; only a bulk erase clears it, and that erase also wipes the fuse words and the signature. A synchronous reset puts the store in its blank, erased state.

Every command keeps the controller busy for a fixed number of cycles, set by a parameter. While it is busy, new commands are dropped without any effect.

Top module: `cfg_store`

## Requirements
- R1: A command is taken when `cmd_valid` is high and `busy` is low. The operation codes are 0 none, 1 fuse write, 2 fuse read, 3 signature write, 4 signature read, 5 set security, 6 preload, 7 bulk erase. `busy` then stays high for exactly BUSY_CYC cycles. `rsp_valid` is high for the single cycle after the last busy cycle.
- R2: A command presented while `busy` is high is ignored. It produces no response and changes no stored word.
- R3: A fuse read at `cmd_addr` returns the word most recently written there. A word never written since reset or erase reads as zero. Commands that are not reads respond with zero data.
- R4: The signature byte index is `cmd_addr[2:0]`. A signature write stores `cmd_wdata[7:0]`. A signature read returns that byte in `rsp_data[7:0]`, with all upper bits zero.
- R5: After the security fuse is set, `secured` is high. A fuse read then returns all-zero data with `rsp_err` high in the response cycle only.
- R6: An accepted preload while unsecured pulses `preload_stb` for one cycle, together with `rsp_valid`, and `preload_data` equals the command's `cmd_wdata`. While secured, a preload gives no strobe and raises `rsp_err` instead.
- R7: Signature reads and writes work the same way while secured, without error.
- R8: The security fuse takes effect for the very next command: a fuse read issued right after the set-security response is refused.
- R9: A bulk erase clears all fuse words, all signature bytes and the security fuse.
- R10: Once set, `secured` stays high through every command other than a bulk erase.
- R11: After reset, `busy`, `rsp_valid`, `rsp_err`, `preload_stb` and `secured` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command present |
| cmd_op | input | 3 | Operation code |
| cmd_addr | input | FUSE_AW | Fuse word address; the low 3 bits give the signature byte index |
| cmd_wdata | input | FUSE_W | Write data, or the preload value |
| busy | output | 1 | A command is executing |
| rsp_valid | output | 1 | Response present for one cycle |
| rsp_data | output | FUSE_W | Read data; zero when refused |
| rsp_err | output | 1 | The command was refused by security |
| secured | output | 1 | The security fuse is set |
| preload_stb | output | 1 | Register preload strobe |
| preload_data | output | FUSE_W | Value to preload |

## Verification
The hardest case to reach is a command that lands on the port while the controller is still busy. It must leave no trace at all: no response, and no write. The bench reaches this case by driving an intruding fuse write to a word in the cycle after a fuse read has been accepted. It then reads that word again and expects the old contents. A second delicate case is the lock boundary. The bench issues a fuse read in the very cycle the set-security response appears, and that read must already be refused.

// File: rtl/cfg_store_pkg.sv
package cfg_store_pkg;
  typedef enum logic [2:0] {
    OP_NOP     = 3'd0,
    OP_FUSE_WR = 3'd1,
    OP_FUSE_RD = 3'd2,
    OP_SIG_WR  = 3'd3,
    OP_SIG_RD  = 3'd4,
    OP_LOCK    = 3'd5,
    OP_PRELOAD = 3'd6,
    OP_ERASE   = 3'd7
  } op_e;
endpackage

// File: rtl/cfg_seq.sv
module cfg_seq
  import cfg_store_pkg::*;
#(
  parameter int AW       = 5,
  parameter int DW       = 16,
  parameter int BUSY_CYC = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cmd_valid,
  input  logic [2:0]    cmd_op,
  input  logic [AW-1:0] cmd_addr,
  input  logic [DW-1:0] cmd_wdata,
  output logic          busy,
  output logic          done,
  output op_e           op_q,
  output logic [AW-1:0] addr_q,
  output logic [DW-1:0] data_q
);
  localparam int CW = $clog2(BUSY_CYC + 1);

  logic [CW-1:0] cnt_q;
  logic          accept;

  assign accept = cmd_valid && !busy;
  assign done   = busy && (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy   <= 1'b0;
      cnt_q  <= '0;
      op_q   <= OP_NOP;
      addr_q <= '0;
      data_q <= '0;
    end else if (accept) begin
      busy   <= 1'b1;
      cnt_q  <= CW'(BUSY_CYC - 1);
      op_q   <= op_e'(cmd_op);
      addr_q <= cmd_addr;
      data_q <= cmd_wdata;
    end else if (busy) begin
      if (cnt_q == '0) busy <= 1'b0;
      else             cnt_q <= cnt_q - 1'b1;
    end
  end

  AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && !busy) |=> busy); // R1
  AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (rst)
    (busy && cmd_valid) |=> ($stable(op_q) && $stable(addr_q) && $stable(data_q))); // R2
endmodule

// File: rtl/cfg_fuse_mem.sv
module cfg_fuse_mem #(
  parameter int AW = 5,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic          clr_all,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0]    mem [DEPTH];
  logic [DW-1:0]    rd_q;
  logic [DEPTH-1:0] written;
  logic             wr_q;

  // plain synchronous array, read-first, no reset: block RAM friendly
  always_ff @(posedge clk) begin
    if (wr_en) mem[addr] <= wdata;
    rd_q <= mem[addr];
  end

  // one flag per word gives a single-cycle bulk erase
  always_ff @(posedge clk) begin
    if (rst || clr_all) begin
      written <= '0;
      wr_q    <= 1'b0;
    end else begin
      if (wr_en) written[addr] <= 1'b1;
      wr_q <= written[addr];
    end
  end

  assign rdata = wr_q ? rd_q : '0;

  AST_CLEAR_BLANK: assert property (@(posedge clk) disable iff (rst)
    clr_all |=> ##1 (rdata == '0)); // R9
endmodule

// File: rtl/cfg_sig_bank.sv
module cfg_sig_bank #(
  parameter int BYTES = 8,
  parameter int IW    = $clog2(BYTES)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic          clr_all,
  input  logic [IW-1:0] idx,
  input  logic [7:0]    wbyte,
  output logic [7:0]    rbyte
);
  logic [7:0] bank [BYTES];

  for (genvar g = 0; g < BYTES; g++) begin : g_byte
    always_ff @(posedge clk) begin
      if (rst || clr_all)                   bank[g] <= '0;
      else if (wr_en && (idx == IW'(g)))    bank[g] <= wbyte;
    end
  end

  assign rbyte = bank[idx];
endmodule

// File: rtl/cfg_store.sv
module cfg_store
  import cfg_store_pkg::*;
#(
  parameter int FUSE_AW   = 5,
  parameter int FUSE_W    = 16,
  parameter int SIG_BYTES = 8,
  parameter int BUSY_CYC  = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cmd_valid,
  input  logic [2:0]         cmd_op,
  input  logic [FUSE_AW-1:0] cmd_addr,
  input  logic [FUSE_W-1:0]  cmd_wdata,
  output logic               busy,
  output logic               rsp_valid,
  output logic [FUSE_W-1:0]  rsp_data,
  output logic               rsp_err,
  output logic               secured,
  output logic               preload_stb,
  output logic [FUSE_W-1:0]  preload_data
);
  localparam int SIG_IW = $clog2(SIG_BYTES);

  logic               done;
  op_e                op_q;
  logic [FUSE_AW-1:0] addr_q;
  logic [FUSE_W-1:0]  data_q;
  logic [FUSE_W-1:0]  fuse_rdata;
  logic [7:0]         sig_rbyte;
  logic               erase_done;

  assign erase_done = done && (op_q == OP_ERASE);

  cfg_seq #(.AW(FUSE_AW), .DW(FUSE_W), .BUSY_CYC(BUSY_CYC)) u_seq (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata), .busy(busy), .done(done),
    .op_q(op_q), .addr_q(addr_q), .data_q(data_q)
  );

  cfg_fuse_mem #(.AW(FUSE_AW), .DW(FUSE_W)) u_fuse (
    .clk(clk), .rst(rst),
    .wr_en(done && (op_q == OP_FUSE_WR)),
    .clr_all(erase_done),
    .addr(addr_q), .wdata(data_q), .rdata(fuse_rdata)
  );

  cfg_sig_bank #(.BYTES(SIG_BYTES), .IW(SIG_IW)) u_sig (
    .clk(clk), .rst(rst),
    .wr_en(done && (op_q == OP_SIG_WR)),
    .clr_all(erase_done),
    .idx(addr_q[SIG_IW-1:0]), .wbyte(data_q[7:0]), .rbyte(sig_rbyte)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid    <= 1'b0;
      rsp_data     <= '0;
      rsp_err      <= 1'b0;
      secured      <= 1'b0;
      preload_stb  <= 1'b0;
      preload_data <= '0;
    end else begin
      rsp_valid   <= done;
      rsp_data    <= '0;
      rsp_err     <= 1'b0;
      preload_stb <= 1'b0;
      if (done) begin
        case (op_q)
          OP_FUSE_RD: begin
            if (secured) rsp_err  <= 1'b1;
            else         rsp_data <= fuse_rdata;
          end
          OP_SIG_RD:  rsp_data <= {{(FUSE_W-8){1'b0}}, sig_rbyte};
          OP_LOCK:    secured  <= 1'b1;
          OP_PRELOAD: begin
            if (secured) rsp_err <= 1'b1;
            else begin
              preload_stb  <= 1'b1;
              preload_data <= data_q;
            end
          end
          OP_ERASE:   secured <= 1'b0;
          default:    ;
        endcase
      end
    end
  end

  AST_RSP_ONE_SHOT: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid); // R1
  AST_BUSY_NO_RSP: assert property (@(posedge clk) disable iff (rst)
    busy |-> !rsp_valid); // R1
  AST_REFUSED_ZERO: assert property (@(posedge clk) disable iff (rst)
    rsp_err |-> (rsp_valid && (rsp_data == '0))); // R5
  AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (rst)
    (secured && !erase_done) |=> secured); // R10
  AST_NO_PRELOAD_SECURE: assert property (@(posedge clk) disable iff (rst)
    (secured && !erase_done) |=> !preload_stb); // R6
endmodule

// File: tb/cfg_store_bench.sv
`timescale 1ns/1ps
module cfg_store_bench;
  localparam int AW = 5;
  localparam int DW = 16;
  localparam int BC = 3;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cmd_valid = 1'b0;
  logic [2:0]    cmd_op = '0;
  logic [AW-1:0] cmd_addr = '0;
  logic [DW-1:0] cmd_wdata = '0;
  logic          busy, rsp_valid, rsp_err, secured, preload_stb;
  logic [DW-1:0] rsp_data, preload_data;

  int errors = 0;
  int checks = 0;

  logic [DW-1:0] q_data[$];
  logic          q_err[$];
  logic          q_stb[$];
  logic [DW-1:0] q_pdata[$];
  string         q_tag[$];

  logic [DW-1:0] m_fuse [1<<AW];
  logic [7:0]    m_sig  [8];
  logic          m_sec;

  always #2.5 clk = ~clk;

  cfg_store #(.FUSE_AW(AW), .FUSE_W(DW), .SIG_BYTES(8), .BUSY_CYC(BC)) u_cfg_store (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata), .busy(busy),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_err(rsp_err),
    .secured(secured), .preload_stb(preload_stb), .preload_data(preload_data)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: responses against scoreboard, busy length, stray pulses
  int busy_run = 0;
  always @(negedge clk) begin
    if (!rst) begin
      if (busy) busy_run++;
      else if (busy_run != 0) begin
        check(busy_run == BC, "R1 busy length", busy_run, BC);
        busy_run = 0;
      end
      if (rsp_valid) begin
        if (q_tag.size() == 0) check(1'b0, "R2 unexpected response", rsp_data, 0);
        else begin
          logic [DW-1:0] ed; logic ee; logic es; logic [DW-1:0] ep; string t;
          ed = q_data.pop_front(); ee = q_err.pop_front(); es = q_stb.pop_front();
          ep = q_pdata.pop_front(); t = q_tag.pop_front();
          check(rsp_data == ed, {t, " data"}, rsp_data, ed);
          check(rsp_err == ee, {t, " err"}, rsp_err, ee);
          check(preload_stb == es, {t, " preload strobe"}, preload_stb, es);
          if (es) check(preload_data == ep, {t, " preload data"}, preload_data, ep);
        end
      end else if (rsp_err || preload_stb) begin
        check(1'b0, "R5 stray pulse outside response", {rsp_err, preload_stb}, 0);
      end
    end
  end

  task automatic wait_idle();
    while (busy) @(negedge clk);
  endtask

  task automatic expect_rsp(input logic [DW-1:0] d, input logic e, input logic s,
                            input logic [DW-1:0] p, input string tag);
    q_data.push_back(d); q_err.push_back(e); q_stb.push_back(s);
    q_pdata.push_back(p); q_tag.push_back(tag);
  endtask

  // drives one command; the model decides the expected response
  task automatic issue(input logic [2:0] op, input logic [AW-1:0] a, input logic [DW-1:0] w,
                       input string tag, input bit intrude = 0);
    logic [DW-1:0] d; logic e; logic s;
    wait_idle();
    d = '0; e = 1'b0; s = 1'b0;
    case (op)
      3'd1: m_fuse[a] = w;
      3'd2: if (m_sec) e = 1'b1; else d = m_fuse[a];
      3'd3: m_sig[a[2:0]] = w[7:0];
      3'd4: d = {8'h00, m_sig[a[2:0]]};
      3'd5: m_sec = 1'b1;
      3'd6: if (m_sec) e = 1'b1; else s = 1'b1;
      3'd7: begin
        m_sec = 1'b0;
        for (int i = 0; i < (1<<AW); i++) m_fuse[i] = '0;
        for (int i = 0; i < 8; i++) m_sig[i] = '0;
      end
      default: ;
    endcase
    expect_rsp(d, e, s, w, tag);
    cmd_valid = 1'b1; cmd_op = op; cmd_addr = a; cmd_wdata = w;
    @(negedge clk);
    if (intrude) begin
      cmd_op = 3'd1; cmd_wdata = 16'hDEAD;   // R2: write while busy
      @(negedge clk);
    end
    cmd_valid = 1'b0; cmd_op = '0;
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    m_sec = 1'b0;
    for (int i = 0; i < (1<<AW); i++) m_fuse[i] = '0;
    for (int i = 0; i < 8; i++) m_sig[i] = '0;
    repeat (3) @(negedge clk);
    // R11 reset state
    check({busy, rsp_valid, rsp_err, preload_stb, secured} == 5'b0, "R11 reset outputs",
          {busy, rsp_valid, rsp_err, preload_stb, secured}, 0);
    rst = 1'b0;
    @(negedge clk);

    issue(3'd2, 5'd4, '0, "R3 blank word reads zero");
    issue(3'd1, 5'd4, 16'hA5C3, "R3 write word 4");
    issue(3'd1, 5'd31, 16'h1234, "R3 write word 31");
    issue(3'd1, 5'd0, 16'hFFFF, "R3 write word 0");
    issue(3'd2, 5'd4, '0, "R3 read word 4");
    issue(3'd2, 5'd31, '0, "R3 read word 31");
    issue(3'd2, 5'd0, '0, "R3 read word 0");

    issue(3'd3, 5'd0, 16'hBE11, "R4 sig write 0");
    issue(3'd3, 5'd7, 16'h00E7, "R4 sig write 7");
    issue(3'd3, 5'd11, 16'hFF5A, "R4 sig write idx 3 via low bits");
    issue(3'd4, 5'd0, '0, "R4 sig read 0");
    issue(3'd4, 5'd7, '0, "R4 sig read 7");
    issue(3'd4, 5'd3, '0, "R4 sig read 3");

    issue(3'd2, 5'd4, '0, "R2 read with intruder", 1);
    issue(3'd2, 5'd4, '0, "R2 word unchanged by intruder");

    issue(3'd6, 5'd0, 16'h3C96, "R6 preload unsecured");
    issue(3'd0, 5'd0, 16'h7777, "R3 nop zero data");

    issue(3'd5, 5'd0, '0, "R5 set security");
    issue(3'd2, 5'd4, '0, "R8 read right after lock refused");
    wait_idle();
    check(secured == 1'b1, "R5 secured flag", secured, 1);
    issue(3'd2, 5'd31, '0, "R5 read refused");
    issue(3'd6, 5'd0, 16'h0F0F, "R6 preload refused");
    issue(3'd4, 5'd7, '0, "R7 sig read while secured");
    issue(3'd3, 5'd2, 16'h0077, "R7 sig write while secured");
    issue(3'd4, 5'd2, '0, "R7 sig readback while secured");
    issue(3'd1, 5'd5, 16'h4444, "R10 fuse write while secured");
    issue(3'd0, 5'd0, '0, "R10 nop while secured");
    wait_idle();
    @(negedge clk);
    check(secured == 1'b1, "R10 secured holds", secured, 1);

    issue(3'd7, 5'd0, '0, "R9 erase");
    wait_idle();
    @(negedge clk);
    check(secured == 1'b0, "R9 security cleared", secured, 0);
    issue(3'd2, 5'd4, '0, "R9 fuse word cleared");
    issue(3'd4, 5'd7, '0, "R9 signature cleared");
    issue(3'd6, 5'd0, 16'h1357, "R9 preload allowed after erase");
    wait_idle();
    repeat (3) @(negedge clk);
    check(q_tag.size() == 0, "R1 all responses seen", q_tag.size(), 0);
    summary();
    $finish;
  end
endmodule